// File: doc/BRIEF.md
# Stop and Wait Clock Gating Controller

This block sits between the main oscillator and the CPU core and decides when the core clock runs. It handles two low-power requests. A stop request parks the core clock high and tells the oscillator to shut down. A wait request parks the clock high and leaves the oscillator running. The gated clock always parks at the high level. It is built so that its enable changes only while the source clock is high, which rules out runt pulses.

The cause of a wake-up sets how long it takes. A reset brings the core clock back at once, and so does an interrupt that ends a wait. An interrupt that ends a stop turns the oscillator back on, but the core clock stays parked until a stabilization counter underflows. That counter is two stages: an 8-bit prescaler ticked by the source clock divided by 16, and an 8-bit timer that steps on each prescaler underflow. On entry to stop, the two stages can be preset automatically. Otherwise they keep values that were loaded earlier through a small valid/ready load port. That port accepts a transfer only while the core clock runs. A source holding `ld_valid` must keep `ld_tmr` and `ld_pre` steady until it sees `ld_ready` high at a rising edge.

Top module: `lpc_clock_ctrl`

## Requirements
- R1: After reset, `clk_cpu` follows `clk_osc`, `osc_en` is 1, `tmr_val` and `pre_val` are 0x00, and `ld_ready` is 1.
- R2: A rising edge with `ld_valid` and `ld_ready` both high loads `ld_tmr` into the timer and `ld_pre` into the prescaler. `ld_ready` is 1 only while the core clock runs, and a load offered while parked changes nothing.
- R3: A stop request honoured at a rising edge drives `osc_en` to 0 and parks `clk_cpu` high from the following low phase onward.
- R4: On stop entry with `preset_hold` = 0, the timer becomes 0x01 and the prescaler 0xFF. With `preset_hold` = 1, both keep their values.
- R5: An interrupt sampled during stop sets `osc_en` to 1 at that edge. After that, the prescaler decrements once every 16 source cycles, and the timer decrements each time the prescaler passes from 0x00 to 0xFF. The clock stays parked until the timer passes from 0x00. With timer t and prescaler p, this makes 16·(p+1+256·t) cycles after the wake edge. Both stages stay frozen for as long as the oscillator is off.
- R6: When stabilization completes, the timer and prescaler both read 0xFF.
- R7: A reset during stop or wait restarts `clk_cpu` immediately, with no stabilization delay, and sets `osc_en` to 1.
- R8: A wait request parks `clk_cpu` high and keeps `osc_en` at 1. An interrupt sampled during wait restarts the clock at that edge and leaves the timer and prescaler untouched.
- R9: While `ring_active` is 1, a stop request is ignored: the clock keeps running and `osc_en` stays 1.
- R10: If stop and wait are requested in the same cycle, stop wins.
- R11: `wake_irq` while the clock runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Enter stop mode |
| wait_req | input | 1 | Enter wait mode |
| wake_irq | input | 1 | Accepted interrupt, wake request |
| preset_hold | input | 1 | 1: keep timer/prescaler on stop entry; 0: preset them |
| ring_active | input | 1 | CPU is clocked by the ring oscillator |
| ld_valid | input | 1 | Load offer for timer and prescaler |
| ld_ready | output | 1 | Load can be accepted (core clock running) |
| ld_tmr | input | 8 | Timer load value |
| ld_pre | input | 8 | Prescaler load value |
| clk_cpu | output | 1 | Gated core clock, parks high |
| osc_en | output | 1 | Main oscillator enable |
| tmr_val | output | 8 | Current timer value |
| pre_val | output | 8 | Current prescaler value |

## Verification
The hardest condition to reach is the middle of a stop release, where the prescaler and timer are counting while the core clock is still parked. A short wake is driven by loading a small count through the port and holding the preset off. This checks the latency formula without waiting long. The default preset is then used for a full 8192-cycle release, and the bench samples both counters part-way through to confirm the divide-by-16 rate and the timer step on prescaler wrap.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAIT = 2'd2,
    ST_WAKE = 2'd3
  } lpc_state_e;
endpackage

// File: rtl/lpc_mode_fsm.sv
module lpc_mode_fsm
  import lpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wait_req,
  input  logic wake_irq,
  input  logic ring_active,
  input  logic stab_done,
  output logic run_next,
  output logic is_run,
  output logic is_wake,
  output logic enter_stop,
  output logic osc_en
);
  lpc_state_e state_q, state_d;
  logic       osc_q;

  // Stop is blocked on the ring oscillator and has priority over wait.
  assign enter_stop = (state_q == ST_RUN) && stop_req && !ring_active;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (enter_stop)    state_d = ST_STOP;
        else if (wait_req) state_d = ST_WAIT;
      end
      ST_STOP: if (wake_irq)  state_d = ST_WAKE;
      ST_WAIT: if (wake_irq)  state_d = ST_RUN;
      ST_WAKE: if (stab_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      osc_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (enter_stop)                              osc_q <= 1'b0;
      else if (state_q == ST_STOP && state_d != ST_STOP) osc_q <= 1'b1;
    end
  end

  assign run_next = (state_d == ST_RUN);
  assign is_run   = (state_q == ST_RUN);
  assign is_wake  = (state_q == ST_WAKE);
  assign osc_en   = osc_q;
endmodule

// File: rtl/lpc_stab_timer.sv
module lpc_stab_timer #(
  parameter int TMR_W      = 8,
  parameter int PRE_W      = 8,
  parameter int DIV        = 16,
  parameter int TMR_PRESET = 1,
  parameter int PRE_PRESET = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             preset_load,
  input  logic             ld_fire,
  input  logic [TMR_W-1:0] ld_tmr,
  input  logic [PRE_W-1:0] ld_pre,
  output logic [TMR_W-1:0] tmr_val,
  output logic [PRE_W-1:0] pre_val,
  output logic             tmr_uf
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [TMR_W-1:0] tmr_q;
  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic             pre_wrap;

  assign tick     = count_en && (div_q == DIV_LAST);
  assign pre_wrap = tick && (pre_q == '0);
  assign tmr_uf   = pre_wrap && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           div_q <= '0;
    else if (!count_en)   div_q <= '0;
    else if (tick)        div_q <= '0;
    else                  div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      pre_q <= '0;
    end else if (preset_load) begin
      tmr_q <= TMR_W'(TMR_PRESET);
      pre_q <= PRE_W'(PRE_PRESET);
    end else if (ld_fire) begin
      tmr_q <= ld_tmr;
      pre_q <= ld_pre;
    end else if (tick) begin
      pre_q <= pre_q - 1'b1;
      if (pre_wrap) tmr_q <= tmr_q - 1'b1;
    end
  end

  assign tmr_val = tmr_q;
  assign pre_val = pre_q;
endmodule

// File: rtl/lpc_clk_gate.sv
module lpc_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_next,
  output logic clk_out
);
  logic en_q;

  // Enable updates on the rising edge, while clk is high, so the OR output
  // stays high across the change and no short pulse can appear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= run_next;
  end

  assign clk_out = clk | ~en_q;
endmodule

// File: rtl/lpc_clock_ctrl.sv
module lpc_clock_ctrl #(
  parameter int TMR_W      = 8,
  parameter int PRE_W      = 8,
  parameter int DIV        = 16,
  parameter int TMR_PRESET = 1,
  parameter int PRE_PRESET = 255
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             wait_req,
  input  logic             wake_irq,
  input  logic             preset_hold,
  input  logic             ring_active,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [TMR_W-1:0] ld_tmr,
  input  logic [PRE_W-1:0] ld_pre,
  output logic             clk_cpu,
  output logic             osc_en,
  output logic [TMR_W-1:0] tmr_val,
  output logic [PRE_W-1:0] pre_val
);
  logic run_next, is_run, is_wake, enter_stop, stab_done;

  lpc_mode_fsm u_fsm (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .wait_req   (wait_req),
    .wake_irq   (wake_irq),
    .ring_active(ring_active),
    .stab_done  (stab_done),
    .run_next   (run_next),
    .is_run     (is_run),
    .is_wake    (is_wake),
    .enter_stop (enter_stop),
    .osc_en     (osc_en)
  );

  lpc_stab_timer #(
    .TMR_W(TMR_W), .PRE_W(PRE_W), .DIV(DIV),
    .TMR_PRESET(TMR_PRESET), .PRE_PRESET(PRE_PRESET)
  ) u_stab (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .count_en   (is_wake),
    .preset_load(enter_stop && !preset_hold),
    .ld_fire    (ld_valid && is_run),
    .ld_tmr     (ld_tmr),
    .ld_pre     (ld_pre),
    .tmr_val    (tmr_val),
    .pre_val    (pre_val),
    .tmr_uf     (stab_done)
  );

  lpc_clk_gate u_gate (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .run_next(run_next),
    .clk_out (clk_cpu)
  );

  assign ld_ready = is_run;
endmodule

// File: rtl/lpc_clock_ctrl_chk.sv
module lpc_clock_ctrl_chk #(
  parameter int TMR_W      = 8,
  parameter int PRE_W      = 8,
  parameter int TMR_PRESET = 1,
  parameter int PRE_PRESET = 255
) (
  input logic             clk_osc,
  input logic             rst_n,
  input logic             stop_req,
  input logic             wait_req,
  input logic             wake_irq,
  input logic             preset_hold,
  input logic             ring_active,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic             osc_en,
  input logic [TMR_W-1:0] tmr_val,
  input logic [PRE_W-1:0] pre_val
);
  p_stop_osc_off_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (ld_ready && stop_req && !ring_active) |=> (!osc_en && !ld_ready));

  p_preset_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (ld_ready && stop_req && !ring_active && !preset_hold) |=>
      (tmr_val == TMR_W'(TMR_PRESET) && pre_val == PRE_W'(PRE_PRESET)));

  p_stop_frozen_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !osc_en |=> ($stable(tmr_val) && $stable(pre_val)));

  p_wait_osc_on_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (ld_ready && wait_req && !stop_req) |=> (osc_en && !ld_ready));

  p_ring_block_r9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (ld_ready && ring_active && !wait_req) |=> (osc_en && ld_ready));

  p_irq_in_run_r11: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (ld_ready && wake_irq && !stop_req && !wait_req && !ld_valid) |=>
      (ld_ready && $stable(tmr_val) && $stable(pre_val)));
endmodule

bind lpc_clock_ctrl lpc_clock_ctrl_chk #(
  .TMR_W(TMR_W), .PRE_W(PRE_W), .TMR_PRESET(TMR_PRESET), .PRE_PRESET(PRE_PRESET)
) u_chk (
  .clk_osc(clk_osc), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
  .wake_irq(wake_irq), .preset_hold(preset_hold), .ring_active(ring_active),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .osc_en(osc_en),
  .tmr_val(tmr_val), .pre_val(pre_val)
);

// File: tb/test_lpc_clock_ctrl.sv
module test_lpc_clock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;

  logic clk_osc = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, wait_req = 0, wake_irq = 0, preset_hold = 0, ring_active = 0;
  logic ld_valid = 0;
  logic [7:0] ld_tmr = '0, ld_pre = '0;
  logic ld_ready, clk_cpu, osc_en;
  logic [7:0] tmr_val, pre_val;

  int checks = 0;
  int errors = 0;

  typedef struct { int lat; string tag; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk_osc = ~clk_osc;

  lpc_clock_ctrl i_lpc_clock_ctrl (
    .clk_osc(clk_osc), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .wake_irq(wake_irq), .preset_hold(preset_hold), .ring_active(ring_active),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_tmr(ld_tmr), .ld_pre(ld_pre),
    .clk_cpu(clk_cpu), .osc_en(osc_en), .tmr_val(tmr_val), .pre_val(pre_val)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measure each parked stretch in low-phase samples, compare to scoreboard.
  initial begin
    int park;
    park = 0;
    forever begin
      @(negedge clk_osc);
      #QTR;
      if (clk_cpu === 1'b1) park++;
      else if (park > 0) begin
        if (exp_q.size() == 0) check(1'b0, "unexpected park", park, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(park == e.lat, e.tag, park, e.lat);
        end
        park = 0;
      end
    end
  end

  // Driver: park for s low phases then wake by irq (kind 0) or reset (kind 1).
  task automatic park_seq(input bit stp, input bit wt, input int s, input bit kind,
                          input int lat, input string tag);
    exp_q.push_back('{lat, tag});
    @(negedge clk_osc);
    stop_req = stp; wait_req = wt;
    @(negedge clk_osc);
    stop_req = 0; wait_req = 0;
  endtask

  task automatic finish_wake(input int s, input bit kind);
    repeat (s - 1) @(negedge clk_osc);
    if (!kind) begin
      wake_irq = 1;
      @(negedge clk_osc);
      wake_irq = 0;
    end else begin
      rst_n = 0;
      @(negedge clk_osc);
      rst_n = 1;
    end
  endtask

  task automatic do_load(input logic [7:0] t, input logic [7:0] p);
    @(negedge clk_osc);
    ld_valid = 1; ld_tmr = t; ld_pre = p;
    @(negedge clk_osc);
    ld_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_osc);
    rst_n = 1;
    @(negedge clk_osc); #QTR;
    // R1 reset state
    check(clk_cpu == 0, "R1 clk_cpu running", clk_cpu, 0);
    check(osc_en == 1, "R1 osc_en", osc_en, 1);
    check(tmr_val == 0 && pre_val == 0, "R1 counters", {tmr_val, pre_val}, 0);
    check(ld_ready == 1, "R1 ld_ready", ld_ready, 1);

    // R2 load
    do_load(8'h00, 8'h03);
    #QTR;
    check(tmr_val == 0 && pre_val == 3, "R2 load", {tmr_val, pre_val}, 3);

    // R11 interrupt while running
    @(negedge clk_osc); wake_irq = 1;
    @(negedge clk_osc); wake_irq = 0; #QTR;
    check(clk_cpu == 0 && ld_ready == 1, "R11 irq in run", clk_cpu, 0);

    // R3/R4/R5: stop with preset held, t=0 p=3 -> 16*4 cycles
    preset_hold = 1;
    park_seq(1, 0, 5, 0, 5 + 64, "R5 short stabilization latency");
    #QTR;
    check(osc_en == 0, "R3 osc off", osc_en, 0);
    check(tmr_val == 0 && pre_val == 3, "R4 held values", {tmr_val, pre_val}, 3);
    check(ld_ready == 0, "R2 ready low parked", ld_ready, 0);
    @(negedge clk_osc); ld_valid = 1; ld_tmr = 8'h07; ld_pre = 8'h07;
    @(negedge clk_osc); ld_valid = 0; #QTR;
    check(tmr_val == 0 && pre_val == 3, "R2 load ignored parked", {tmr_val, pre_val}, 3);
    finish_wake(5 - 2, 0);
    #QTR;
    check(osc_en == 1, "R5 osc on after irq", osc_en, 1);
    repeat (80) @(negedge clk_osc); #QTR;
    check(tmr_val == 8'hFF && pre_val == 8'hFF, "R6 wrapped values", {tmr_val, pre_val}, 16'hFFFF);

    // R4/R5/R6: stop with preset, 16*512 cycles
    preset_hold = 0;
    park_seq(1, 0, 3, 0, 3 + 8192, "R5 full stabilization latency");
    #QTR;
    check(tmr_val == 1 && pre_val == 8'hFF, "R4 preset values", {tmr_val, pre_val}, 16'h01FF);
    finish_wake(3, 0);
    repeat (39) @(negedge clk_osc); #QTR;
    check(tmr_val == 1 && pre_val == 8'hFD, "R5 prescaler rate", {tmr_val, pre_val}, 16'h01FD);
    check(clk_cpu == 1, "R5 still parked", clk_cpu, 1);
    repeat (8200) @(negedge clk_osc); #QTR;
    check(tmr_val == 8'hFF && pre_val == 8'hFF, "R6 after full wait", {tmr_val, pre_val}, 16'hFFFF);

    // R8 wait mode, interrupt wake
    do_load(8'h05, 8'h06);
    park_seq(0, 1, 4, 0, 4, "R8 wait latency");
    #QTR;
    check(osc_en == 1, "R8 osc stays on", osc_en, 1);
    finish_wake(4, 0);
    #QTR;
    check(tmr_val == 5 && pre_val == 6, "R8 counters untouched", {tmr_val, pre_val}, 16'h0506);

    // R7 reset ends wait
    park_seq(0, 1, 4, 1, 3, "R7 reset ends wait");
    finish_wake(4, 1);
    #QTR;
    check(tmr_val == 0 && pre_val == 0, "R7 reset counters", {tmr_val, pre_val}, 0);

    // R7 reset ends stop without stabilization
    do_load(8'h02, 8'h10);
    preset_hold = 1;
    park_seq(1, 0, 6, 1, 5, "R7 reset ends stop");
    finish_wake(6, 1);
    #QTR;
    check(osc_en == 1 && clk_cpu == 0, "R7 osc on clock running", osc_en, 1);

    // R9 ring oscillator blocks stop
    ring_active = 1;
    @(negedge clk_osc); stop_req = 1;
    @(negedge clk_osc); stop_req = 0; #QTR;
    check(clk_cpu == 0, "R9 clock keeps running", clk_cpu, 0);
    check(osc_en == 1, "R9 osc stays on", osc_en, 1);
    ring_active = 0;

    // R10 stop wins over wait; counters 0/0 -> 16 cycles
    park_seq(1, 1, 3, 0, 3 + 16, "R10 stop priority latency");
    #QTR;
    check(osc_en == 0, "R10 stop chosen", osc_en, 0);
    finish_wake(3, 0);

    repeat (40) @(negedge clk_osc); #QTR;
    check(exp_q.size() == 0, "R5 all parks observed", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule